// File: doc/BRIEF.md
# Comparator Output Event Controller

This block is the digital back end of an analog voltage comparator. The comparator's one-bit decision arrives with no relation to the bus clock. The block passes it through a two-stage synchronizer. It then gates the synchronized value through a hold stage that stays frozen for a fixed number of cycles after the block is switched on. This masks the glitches of the analog start-up. The gated value appears as a readable result bit. An edge detector watches the gated value. According to a two-bit mode, it sets a sticky event flag on rising edges, on falling edges, on both, or on neither.

Software drives the block through a small register port with two locations. The control word holds the enable, the edge mode, an interrupt enable, a capture routing enable and a pin output enable. The status word holds the gated result and the flag, and the flag is cleared by writing a one to it. The interrupt request is the flag qualified by its enable. The gated result can be routed to a timer capture input. The raw, unsynchronized comparator level can be driven to a pin.

The held value starts at zero after reset and survives a disable. Because of this, an input that settles high during the first start-up window, or that settles opposite to the held value during a later one, yields an edge, and often a flag, at the moment the window closes.

Top module: `cmp_event_ctrl`

## Requirements
- R1: While the hold stage is open, a change of `cmp_raw_i` driven between clock edges shows in status bit 0 after the third rising edge, and not after the second.
- R2: The enable is control bit 0. Once it goes from 0 to 1 by a control write, status bit 0 keeps its held value through the HOLD_CYCLES rising edges that follow the write edge. It first takes the synchronized input on edge HOLD_CYCLES+1. With the default HOLD_CYCLES = 63, an input held high from reset reads 0 after 63 edges and 1 after 64.
- R3: While the enable is 0, status bit 0 and the flag ignore `cmp_raw_i`. A later re-enable restarts the full hold window from the held value, and a value opposite to it at window close counts as an edge.
- R4: The mode is control bits [2:1]. 00 never sets the flag, 01 sets it on a rising edge of the gated value, 10 on a falling edge, and 11 on either.
- R5: The flag (status bit 1) becomes 1 one rising edge after status bit 0 shows a qualifying edge.
- R6: A status write with data bit 1 set clears the flag. A status write with data bit 1 clear leaves it unchanged.
- R7: When a qualifying edge and a clearing write fall on the same clock edge, the flag ends up set.
- R8: `irq_o` is 1 exactly when the interrupt enable (control bit 3) and the flag are both 1.
- R9: With capture enable (control bit 4) set, `capture_o` equals the gated result; otherwise it is 0.
- R10: With pin output enable (control bit 5) set, `pin_o` follows `cmp_raw_i` combinationally with no clock delay; otherwise it is 0.
- R11: Address 0 reads back the control word and address 1 reads {0000, flag, result}. After reset both read 0, and `irq_o`, `capture_o` and `pin_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmp_raw_i | input | 1 | Asynchronous comparator decision |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 control, 1 status |
| wr_data_i | input | 6 | Write data |
| rd_addr_i | input | 1 | Read address: 0 control, 1 status |
| rd_data_o | output | 6 | Read data, combinational from the read address |
| irq_o | output | 1 | Interrupt request |
| capture_o | output | 1 | Gated result towards a timer capture channel |
| pin_o | output | 1 | Raw comparator level towards a pin |

## Verification
The hardest situation to reach from the ports is a qualifying edge arriving on the same clock edge as a flag-clearing write. The stimulus changes the input between edges. It counts the two synchronizer stages and the gate register. It then lines up the clearing write so that it lands on the fourth edge, where the flag is set. The spurious-looking flags after re-enable are reached in a similar way. The bench disables the block while the held value is 1, flips the input, re-enables it, and then counts edges to both sides of the window's close.

// File: rtl/cmp_event_pkg.sv
package cmp_event_pkg;

  localparam int REG_W = 6;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  // control word, bit 0 at the bottom
  typedef struct packed {
    logic       pin_oe;
    logic       cap_en;
    logic       irq_en;
    edge_mode_e mode;
    logic       enable;
  } ctrl_t;

endpackage

// File: rtl/cmp_rst_sync.sv
module cmp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/cmp_hold_gate.sv
module cmp_hold_gate #(
  parameter int HOLD_CYCLES = 63,
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             sync_i,
  output logic             gated_o,
  output logic             open_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             gated_q, gated_d;
  logic             open;

  // counter sits at zero while off, climbs to CNT_MAX once on
  always_comb begin
    open    = enable_i && (cnt_q == CNT_MAX);
    cnt_d   = cnt_q;
    gated_d = gated_q;
    if (!enable_i)             cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    if (open)                  gated_d = sync_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      gated_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      gated_q <= gated_d;
    end
  end

  assign gated_o = gated_q;
  assign open_o  = open;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/cmp_edge_flag.sv
module cmp_edge_flag
  import cmp_event_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gated_i,
  input  edge_mode_e mode_i,
  input  logic       clr_i,
  output logic       flag_o,
  output logic       set_o
);

  logic prev_q;
  logic flag_q, flag_d;
  logic rise, fall, set;

  always_comb begin
    rise = gated_i & ~prev_q;
    fall = ~gated_i & prev_q;
    case (mode_i)
      EDGE_RISE: set = rise;
      EDGE_FALL: set = fall;
      EDGE_ANY:  set = rise | fall;
      default:   set = 1'b0;
    endcase
    // hardware set takes priority over the software clear
    flag_d = set | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= gated_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign set_o  = set;

endmodule

// File: rtl/cmp_event_ctrl.sv
module cmp_event_ctrl
  import cmp_event_pkg::*;
#(
  parameter int HOLD_CYCLES = 63,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_raw_i,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_addr_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o,
  output logic             capture_o,
  output logic             pin_o
);

  logic             rst_n_s;
  ctrl_t            ctrl_q, ctrl_d;
  logic             flag_clr;
  logic             sync_val;
  logic             gated;
  logic             gate_open;
  logic [CNT_W-1:0] hold_cnt;
  logic             flag;
  logic             flag_set;
  logic             en_w;
  edge_mode_e       mode_w;

  cmp_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  always_comb begin
    ctrl_d   = ctrl_q;
    if (wr_en_i && !wr_addr_i) ctrl_d = ctrl_t'(wr_data_i);
    flag_clr = wr_en_i && wr_addr_i && wr_data_i[1];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) ctrl_q <= '0;
    else          ctrl_q <= ctrl_d;
  end

  assign en_w   = ctrl_q.enable;
  assign mode_w = ctrl_q.mode;

  cmp_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (cmp_raw_i),
    .q_o   (sync_val)
  );

  cmp_hold_gate #(.HOLD_CYCLES(HOLD_CYCLES)) i_hold (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .enable_i (en_w),
    .sync_i   (sync_val),
    .gated_o  (gated),
    .open_o   (gate_open),
    .cnt_o    (hold_cnt)
  );

  cmp_edge_flag i_flag (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .gated_i (gated),
    .mode_i  (mode_w),
    .clr_i   (flag_clr),
    .flag_o  (flag),
    .set_o   (flag_set)
  );

  always_comb begin
    if (rd_addr_i) rd_data_o = {{(REG_W-2){1'b0}}, flag, gated};
    else           rd_data_o = ctrl_q;
  end

  assign irq_o     = ctrl_q.irq_en & flag;
  assign capture_o = ctrl_q.cap_en & gated;
  assign pin_o     = ctrl_q.pin_oe & cmp_raw_i;

endmodule

// File: rtl/cmp_event_chk.sv
module cmp_event_chk #(
  parameter int HOLD_CYCLES = 63,
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             gate_open,
  input logic             gated,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       mode,
  input logic             flag,
  input logic             set,
  input logic             clr,
  input logic             irq,
  input logic             cap_en,
  input logic             capture
);

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_open |=> $stable(gated)); // R2

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(HOLD_CYCLES)); // R2

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt == '0)); // R3

  AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> !$rose(flag)); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag); // R7

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag); // R8

  AST_CAP_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |-> !capture); // R9

endmodule

bind cmp_event_ctrl cmp_event_chk #(.HOLD_CYCLES(HOLD_CYCLES)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .enable    (en_w),
  .gate_open (gate_open),
  .gated     (gated),
  .cnt       (hold_cnt),
  .mode      (mode_w),
  .flag      (flag),
  .set       (flag_set),
  .clr       (flag_clr),
  .irq       (irq_o),
  .cap_en    (ctrl_q.cap_en),
  .capture   (capture_o)
);

// File: tb/test_cmp_event_ctrl.sv
`timescale 1ns/1ps
module test_cmp_event_ctrl;

  localparam int HOLD = 63;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_raw = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [5:0] wr_data = '0;
  logic       rd_addr = 1'b0;
  logic [5:0] rd_data;
  logic       irq, capture, pin;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  cmp_event_ctrl #(.HOLD_CYCLES(HOLD)) i_cmp_event_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_raw_i (cmp_raw),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .irq_o     (irq),
    .capture_o (capture),
    .pin_o     (pin)
  );

  // {mode[1:0], start level, new level, expected flag}
  localparam logic [4:0] VEC [8] = '{
    5'b00_0_1_0, 5'b01_0_1_1, 5'b01_1_0_0, 5'b10_1_0_1,
    5'b10_0_1_0, 5'b11_0_1_1, 5'b11_1_0_1, 5'b00_1_0_0
  };

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [5:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic a, output logic [5:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      report();
      $finish;
    end
  end

  initial begin
    logic [5:0] v;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);

    // R11 reset state
    rd(1'b0, v); check("R11 ctrl reset", v, 0);
    rd(1'b1, v); check("R11 status reset", v, 0);
    check("R11 irq reset", irq, 0);
    check("R11 capture reset", capture, 0);
    check("R11 pin reset", pin, 0);

    // R2 first window, input high from the start; R5 flag timing
    cmp_raw = 1'b1;
    wait_cyc(5);
    wr(1'b0, 6'h0B);
    wait_cyc(HOLD);
    rd(1'b1, v); check("R2 result held at window end", v[0], 0);
    wait_cyc(1);
    rd(1'b1, v); check("R2 result released", v[0], 1);
    check("R5 flag not yet", v[1], 0);
    wait_cyc(1);
    rd(1'b1, v); check("R5 flag set after close", v[1], 1);
    check("R8 irq with enable", irq, 1);

    // R8 interrupt enable off
    wr(1'b0, 6'h03);
    check("R8 irq masked", irq, 0);
    wr(1'b0, 6'h0B);

    // R6 write zero then write one
    wr(1'b1, 6'h00);
    rd(1'b1, v); check("R6 write zero keeps flag", v[1], 1);
    wr(1'b1, 6'h02);
    rd(1'b1, v); check("R6 write one clears flag", v[1], 0);

    // R1 synchronizer latency
    @(negedge clk);
    cmp_raw = 1'b0;
    wait_cyc(2);
    rd(1'b1, v); check("R1 unchanged after two edges", v[0], 1);
    wait_cyc(1);
    rd(1'b1, v); check("R1 changed after three edges", v[0], 0);

    // R4 edge modes from the table
    foreach (VEC[i]) begin
      wr(1'b0, {3'b001, VEC[i][4:3], 1'b1});
      cmp_raw = VEC[i][2];
      wait_cyc(6);
      wr(1'b1, 6'h02);
      cmp_raw = VEC[i][1];
      wait_cyc(6);
      rd(1'b1, v);
      check($sformatf("R4 mode %0d vector %0d", VEC[i][4:3], i), v[1], VEC[i][0]);
    end

    // R7 set and clear on the same edge
    wr(1'b0, 6'h0B);
    wait_cyc(2);
    wr(1'b1, 6'h02);
    @(negedge clk);
    cmp_raw = 1'b1;
    wait_cyc(3);
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 6'h02;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    rd(1'b1, v); check("R7 set wins over clear", v[1], 1);

    // R3 disable, flip input, re-enable with falling mode
    wr(1'b0, 6'h0C);
    wr(1'b1, 6'h02);
    cmp_raw = 1'b0;
    wait_cyc(10);
    rd(1'b1, v); check("R3 result ignores input while off", v[0], 1);
    check("R3 flag ignores input while off", v[1], 0);
    wr(1'b0, 6'h0D);
    wait_cyc(HOLD);
    rd(1'b1, v); check("R3 held value kept in new window", v[0], 1);
    wait_cyc(1);
    rd(1'b1, v); check("R3 result released after re-enable", v[0], 0);
    wait_cyc(1);
    rd(1'b1, v); check("R3 flag from edge at close", v[1], 1);

    // R9 capture routing
    wr(1'b0, 6'h11);
    check("R9 capture follows low result", capture, 0);
    cmp_raw = 1'b1;
    wait_cyc(4);
    check("R9 capture follows high result", capture, 1);
    wr(1'b0, 6'h01);
    check("R9 capture off", capture, 0);

    // R10 raw pin output
    wr(1'b0, 6'h21);
    cmp_raw = 1'b0; #1;
    check("R10 pin low", pin, 0);
    cmp_raw = 1'b1; #1;
    check("R10 pin follows raw at once", pin, 1);
    wr(1'b0, 6'h01);
    check("R10 pin off", pin, 0);
    rd(1'b0, v); check("R11 ctrl readback", v, 6'h01);

    report();
    $finish;
  end

endmodule